// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block is the trap-control slice of a processor hart that supports non-maskable interrupts from which execution can resume. Each cycle it looks at the NMI request lines, the current PC and privilege mode, an exception strobe with its cause, and a strobe for a decoded NMI-return instruction. From these it decides whether to enter the NMI handler, take a nested exception to a dedicated vector, return from the NMI handler, or do nothing. The redirect it produces (valid, target PC, new privilege) is combinational in the same cycle as the inputs. The saved state and the internal enable bit update at the next clock edge.

The block holds four machine-mode CSRs: a scratch word, the saved PC, the saved cause and a status word. It also holds a hidden enable bit. That bit blocks further NMIs while it is clear, and it also gates every other interrupt through `irq_en_o`. For the ordinary trap CSRs the block only drives write strobes, and only on the nested-exception path. All pins are plain control and status signals with no handshake. A redirect is a single-cycle strobe that the pipeline must accept in the cycle it is shown. CSR reads are combinational from the address, and CSR writes commit at the next edge.

Top module: `rnmi_trap_ctl`

## Requirements
- R1: The scratch CSR at address 0x350 is XLEN bits wide and fully read-write. For any address outside 0x350–0x353, `csr_hit_o` is 0 and `csr_rdata_o` is 0.
- R2: The saved-PC CSR (0x351) always reads bit 0 as zero, and writes to bit 0 are ignored.
- R3: In the status CSR (0x353), only bits [12:11] hold state. All other bits read as zero whatever was written.
- R4: When an NMI is taken, the redirect goes to parameter `NMI_VEC` with `priv_o` = 2'b11 (machine). After the edge: the saved PC holds `pc_i` with bit 0 cleared, status[12:11] holds the prior `priv_i`, and `irq_en_o` is 0.
- R5: The saved cause on NMI entry has bit XLEN-1 set to 1. Its low bits hold the index of the lowest-numbered active request line, and all other bits are 0.
- R6: When the enable bit is set, an NMI outranks a same-cycle exception or NMI-return: no nested write, no illegal strobe and no return take place. When the enable bit is clear, NMI requests are ignored: there is no redirect and the NMI CSRs keep their values.
- R7: `irq_en_o` shows the enable bit, and it is 1 after reset. After reset all NMI CSRs read as 0.
- R8: An NMI-return in machine mode (`priv_i` = 2'b11), with no exception and no NMI taken, redirects to the saved PC with `priv_o` = status[12:11]. It sets the enable bit.
- R9: An exception while the enable bit is clear drives, in the same cycle, `mepc_we_o` with `mepc_o` = `pc_i`, `mcause_we_o` with `mcause_o` = `exc_cause_i`, and `mpp_we_o` with `mpp_o` = 2'b11. It redirects to parameter `NMI_EXC_VEC` in machine mode and leaves the NMI CSRs unchanged.
- R10: An exception while the enable bit is set produces no redirect and no mepc/mcause/MPP write from this block.
- R11: An NMI-return outside machine mode does not return. If the enable bit is set, it pulses `mnret_ill_o`. If the enable bit is clear, it takes the nested path of R9 with cause 2.
- R12: A CSR write in the same cycle as NMI entry is dropped. The capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req_i | input | NMI_LINES | NMI request lines, level sensitive |
| pc_i | input | XLEN | PC of the instruction at the trap point |
| priv_i | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| exc_valid_i | input | 1 | Exception raised this cycle |
| exc_cause_i | input | XLEN | Cause of that exception |
| mnret_i | input | 1 | Decoded NMI-return instruction this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| csr_hit_o | output | 1 | Address selects one of the four NMI CSRs |
| redirect_valid_o | output | 1 | PC redirect this cycle |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Privilege to switch to with the redirect |
| irq_en_o | output | 1 | Global interrupt gate (enable bit) |
| mnret_ill_o | output | 1 | Illegal NMI-return to raise as cause 2 on the normal path |
| mepc_we_o | output | 1 | Write strobe for mepc |
| mepc_o | output | XLEN | Value for mepc |
| mcause_we_o | output | 1 | Write strobe for mcause |
| mcause_o | output | XLEN | Value for mcause |
| mpp_we_o | output | 1 | Write strobe for mstatus.MPP |
| mpp_o | output | 2 | Value for mstatus.MPP |

## Verification
The entry path is tried from supervisor mode and from user mode, each time with a different set of request lines. This separates capture of the prior privilege from the forced machine mode, and shows that the lowest active line sets the cause. Entry is also raised together with an exception and together with a CSR write, which shows that the NMI outranks both. With the enable bit clear, two patterns are applied: a bare NMI request, which must leave everything untouched, and an exception or out-of-mode return, which must take the dedicated vector. The same stimuli with the bit set then show that the enable bit alone chooses between these outcomes.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;
  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_NMI  = 2'd1,
    ACT_NEST = 2'd2,
    ACT_RET  = 2'd3
  } act_e;

  localparam logic [11:0] CSR_NSCRATCH = 12'h350;
  localparam logic [11:0] CSR_NEPC     = 12'h351;
  localparam logic [11:0] CSR_NCAUSE   = 12'h352;
  localparam logic [11:0] CSR_NSTATUS  = 12'h353;
  localparam int          PP_LO        = 11;
  localparam int          ILL_CAUSE    = 2;
endpackage

// File: rtl/rnmi_line_pick.sv
module rnmi_line_pick #(
  parameter int LINES = 4,
  parameter int IDXW  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] req_i,
  output logic             any_o,
  output logic [IDXW-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[IDXW-1:0];
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/rnmi_trap_seq.sv
module rnmi_trap_seq
  import rnmi_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_any_i,
  input  priv_e           priv_i,
  input  logic            exc_valid_i,
  input  logic [XLEN-1:0] exc_cause_i,
  input  logic            mnret_i,
  output act_e            act_o,
  output logic [XLEN-1:0] fault_cause_o,
  output logic            mnret_ill_o,
  output logic            en_o
);
  logic en_q;
  logic ret_ok, ret_bad, fault;

  always_comb begin
    ret_ok  = mnret_i && (priv_i == PRIV_M);
    ret_bad = mnret_i && (priv_i != PRIV_M);
    fault   = exc_valid_i || ret_bad;
    act_o   = ACT_NONE;
    if (nmi_any_i && en_q)      act_o = ACT_NMI;
    else if (fault && !en_q)    act_o = ACT_NEST;
    else if (!fault && ret_ok)  act_o = ACT_RET;
  end

  assign fault_cause_o = exc_valid_i ? exc_cause_i : XLEN'(ILL_CAUSE);
  assign mnret_ill_o   = ret_bad && en_q && !nmi_any_i && !exc_valid_i;
  assign en_o          = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_q <= 1'b1;
    else if (act_o == ACT_NMI) en_q <= 1'b0;
    else if (act_o == ACT_RET) en_q <= 1'b1;
  end

  AST_RET_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (mnret_i && priv_i == PRIV_M && !exc_valid_i && !(en_q && nmi_any_i)) |=> en_q); // R8

  AST_NMI_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && nmi_any_i) |-> (!mnret_ill_o && act_o != ACT_NEST)); // R6
endmodule

// File: rtl/rnmi_csr_file.sv
module rnmi_csr_file
  import rnmi_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic [XLEN-1:0] cap_pc_i,
  input  logic [XLEN-1:0] cap_cause_i,
  input  logic [1:0]      cap_priv_i,
  input  logic [11:0]     addr_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            hit_o,
  output logic [XLEN-1:0] epc_o,
  output logic [1:0]      pp_o
);
  localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

  logic [XLEN-1:0] scratch_q, epc_q, cause_q;
  logic [1:0]      pp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      pp_q      <= '0;
    end else if (cap_i) begin
      epc_q   <= cap_pc_i & EVEN_MASK;
      cause_q <= cap_cause_i;
      pp_q    <= cap_priv_i;
    end else if (we_i) begin
      case (addr_i)
        CSR_NSCRATCH: scratch_q <= wdata_i;
        CSR_NEPC:     epc_q     <= wdata_i & EVEN_MASK;
        CSR_NCAUSE:   cause_q   <= wdata_i;
        CSR_NSTATUS:  pp_q      <= wdata_i[PP_LO+1:PP_LO];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b1;
    case (addr_i)
      CSR_NSCRATCH: rdata_o = scratch_q;
      CSR_NEPC:     rdata_o = epc_q;
      CSR_NCAUSE:   rdata_o = cause_q;
      CSR_NSTATUS:  rdata_o[PP_LO+1:PP_LO] = pp_q;
      default:      hit_o = 1'b0;
    endcase
  end

  assign epc_o = epc_q;
  assign pp_o  = pp_q;

  AST_CAUSE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && cap_cause_i[XLEN-1]) |=> cause_q[XLEN-1]); // R5

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && we_i && addr_i == CSR_NSCRATCH) |=> $stable(scratch_q)); // R12
endmodule

// File: rtl/rnmi_trap_ctl.sv
module rnmi_trap_ctl
  import rnmi_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              NMI_LINES   = 4,
  parameter logic [XLEN-1:0] NMI_VEC     = 32'h0000_1000,
  parameter logic [XLEN-1:0] NMI_EXC_VEC = 32'h0000_1100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NMI_LINES-1:0] nmi_req_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [1:0]           priv_i,
  input  logic                 exc_valid_i,
  input  logic [XLEN-1:0]      exc_cause_i,
  input  logic                 mnret_i,
  input  logic [11:0]          csr_addr_i,
  input  logic                 csr_we_i,
  input  logic [XLEN-1:0]      csr_wdata_i,
  output logic [XLEN-1:0]      csr_rdata_o,
  output logic                 csr_hit_o,
  output logic                 redirect_valid_o,
  output logic [XLEN-1:0]      redirect_pc_o,
  output logic [1:0]           priv_o,
  output logic                 irq_en_o,
  output logic                 mnret_ill_o,
  output logic                 mepc_we_o,
  output logic [XLEN-1:0]      mepc_o,
  output logic                 mcause_we_o,
  output logic [XLEN-1:0]      mcause_o,
  output logic                 mpp_we_o,
  output logic [1:0]           mpp_o
);
  localparam int IDXW = (NMI_LINES > 1) ? $clog2(NMI_LINES) : 1;

  logic            nmi_any;
  logic [IDXW-1:0] nmi_idx;
  act_e            act;
  logic [XLEN-1:0] fault_cause;
  logic [XLEN-1:0] nmi_cause;
  logic [XLEN-1:0] saved_pc;
  logic [1:0]      saved_pp;

  rnmi_line_pick #(.LINES(NMI_LINES), .IDXW(IDXW)) u_pick (
    .req_i (nmi_req_i),
    .any_o (nmi_any),
    .idx_o (nmi_idx)
  );

  rnmi_trap_seq #(.XLEN(XLEN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .nmi_any_i     (nmi_any),
    .priv_i        (priv_e'(priv_i)),
    .exc_valid_i   (exc_valid_i),
    .exc_cause_i   (exc_cause_i),
    .mnret_i       (mnret_i),
    .act_o         (act),
    .fault_cause_o (fault_cause),
    .mnret_ill_o   (mnret_ill_o),
    .en_o          (irq_en_o)
  );

  always_comb begin
    nmi_cause            = '0;
    nmi_cause[XLEN-1]    = 1'b1;
    nmi_cause[IDXW-1:0]  = nmi_idx;
  end

  rnmi_csr_file #(.XLEN(XLEN)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_i       (act == ACT_NMI),
    .cap_pc_i    (pc_i),
    .cap_cause_i (nmi_cause),
    .cap_priv_i  (priv_i),
    .addr_i      (csr_addr_i),
    .we_i        (csr_we_i),
    .wdata_i     (csr_wdata_i),
    .rdata_o     (csr_rdata_o),
    .hit_o       (csr_hit_o),
    .epc_o       (saved_pc),
    .pp_o        (saved_pp)
  );

  always_comb begin
    redirect_valid_o = 1'b1;
    redirect_pc_o    = '0;
    priv_o           = priv_i;
    case (act)
      ACT_NMI:  begin redirect_pc_o = NMI_VEC;     priv_o = PRIV_M;   end
      ACT_NEST: begin redirect_pc_o = NMI_EXC_VEC; priv_o = PRIV_M;   end
      ACT_RET:  begin redirect_pc_o = saved_pc;    priv_o = saved_pp; end
      default:  redirect_valid_o = 1'b0;
    endcase
  end

  assign mepc_we_o   = (act == ACT_NEST);
  assign mcause_we_o = (act == ACT_NEST);
  assign mpp_we_o    = (act == ACT_NEST);
  assign mepc_o      = pc_i;
  assign mcause_o    = fault_cause;
  assign mpp_o       = PRIV_M;

  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_o && |nmi_req_i) |=> !irq_en_o); // R4

  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_o && !(csr_we_i && csr_addr_i == CSR_NEPC)) |=> $stable(saved_pc)); // R6

  AST_NEST_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we_o |-> (mcause_we_o && mpp_we_o && !irq_en_o && redirect_pc_o == NMI_EXC_VEC)); // R9

  AST_ENABLED_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_o |-> !mepc_we_o); // R10
endmodule

// File: tb/rnmi_trap_ctl_tb_top.sv
module rnmi_trap_ctl_tb_top;
  localparam logic [31:0] NV = 32'h0000_1000;
  localparam logic [31:0] EV = 32'h0000_1100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  nmi_req = '0;
  logic [31:0] pc = '0;
  logic [1:0]  priv = 2'b11;
  logic        exc_valid = 1'b0;
  logic [31:0] exc_cause = '0;
  logic        mnret = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata, redirect_pc, mepc, mcause;
  logic        csr_hit, redirect_valid, irq_en, mnret_ill, mepc_we, mcause_we, mpp_we;
  logic [1:0]  priv_out, mpp;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rnmi_trap_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi_req), .pc_i(pc), .priv_i(priv),
    .exc_valid_i(exc_valid), .exc_cause_i(exc_cause), .mnret_i(mnret),
    .csr_addr_i(csr_addr), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .csr_hit_o(csr_hit),
    .redirect_valid_o(redirect_valid), .redirect_pc_o(redirect_pc), .priv_o(priv_out),
    .irq_en_o(irq_en), .mnret_ill_o(mnret_ill),
    .mepc_we_o(mepc_we), .mepc_o(mepc), .mcause_we_o(mcause_we), .mcause_o(mcause),
    .mpp_we_o(mpp_we), .mpp_o(mpp)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    nmi_req = '0; exc_valid = 1'b0; mnret = 1'b0; csr_we = 1'b0;
  endtask

  // Apply current inputs through one edge, then return to idle at negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    step();
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R7 en after reset", {31'b0, irq_en}, 32'd1);
    chk("R7 no redirect", {31'b0, redirect_valid}, 32'd0);
    rd(12'h351, v); chk("R7 saved pc reset", v, 32'd0);
    rd(12'h352, v); chk("R7 cause reset", v, 32'd0);
  endtask

  task automatic t_csr_fields();
    logic [31:0] v;
    wr(12'h350, 32'hDEAD_BEEF);
    rd(12'h350, v); chk("R1 scratch rw", v, 32'hDEAD_BEEF);
    rd(12'h354, v); chk("R1 unmapped data", v, 32'd0);
    chk("R1 unmapped hit", {31'b0, csr_hit}, 32'd0);
    wr(12'h351, 32'h0000_1235);
    rd(12'h351, v); chk("R2 pc bit0", v, 32'h0000_1234);
    wr(12'h353, 32'hFFFF_FFFF);
    rd(12'h353, v); chk("R3 status mask", v, 32'h0000_1800);
    wr(12'h353, 32'h0);
  endtask

  task automatic t_entry_s();
    logic [31:0] v;
    priv = 2'b01; pc = 32'h8000_0043; nmi_req = 4'b0110;
    exc_valid = 1'b1; exc_cause = 32'd5; mnret = 1'b1; #1;
    chk("R4 redirect valid", {31'b0, redirect_valid}, 32'd1);
    chk("R4 vector", redirect_pc, NV);
    chk("R4 priv M", {30'b0, priv_out}, 32'd3);
    chk("R6 no nested write", {31'b0, mepc_we}, 32'd0);
    chk("R6 no illegal", {31'b0, mnret_ill}, 32'd0);
    step();
    chk("R4 en cleared", {31'b0, irq_en}, 32'd0);
    rd(12'h351, v); chk("R4 saved pc", v, 32'h8000_0042);
    rd(12'h352, v); chk("R5 cause", v, 32'h8000_0001);
    rd(12'h353, v); chk("R4 saved priv", v, 32'h0000_0800);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    priv = 2'b11; pc = 32'h0000_1234; nmi_req = 4'b0001; #1;
    chk("R6 masked no redirect", {31'b0, redirect_valid}, 32'd0);
    step();
    rd(12'h351, v); chk("R6 masked pc kept", v, 32'h8000_0042);
    rd(12'h352, v); chk("R6 masked cause kept", v, 32'h8000_0001);
  endtask

  task automatic t_nested();
    logic [31:0] v;
    pc = 32'h0000_0300; exc_valid = 1'b1; exc_cause = 32'd5; #1;
    chk("R9 redirect", {31'b0, redirect_valid}, 32'd1);
    chk("R9 vector", redirect_pc, EV);
    chk("R9 priv", {30'b0, priv_out}, 32'd3);
    chk("R9 mepc we", {31'b0, mepc_we}, 32'd1);
    chk("R9 mepc", mepc, 32'h0000_0300);
    chk("R9 mcause", mcause, 32'd5);
    chk("R9 mpp", {29'b0, mcause_we, mpp_we, 1'b0} | {30'b0, mpp}, 32'h7);
    step();
    rd(12'h351, v); chk("R9 nmi csr kept", v, 32'h8000_0042);
    chk("R9 en still clear", {31'b0, irq_en}, 32'd0);
  endtask

  task automatic t_return(input logic [31:0] exp_pc, input logic [1:0] exp_pp);
    priv = 2'b11; mnret = 1'b1; #1;
    chk("R8 redirect", {31'b0, redirect_valid}, 32'd1);
    chk("R8 target", redirect_pc, exp_pc);
    chk("R8 priv", {30'b0, priv_out}, {30'b0, exp_pp});
    step();
    chk("R8 en set", {31'b0, irq_en}, 32'd1);
  endtask

  task automatic t_exc_enabled();
    pc = 32'h0000_0400; exc_valid = 1'b1; exc_cause = 32'd7; #1;
    chk("R10 no redirect", {31'b0, redirect_valid}, 32'd0);
    chk("R10 no mepc write", {31'b0, mepc_we}, 32'd0);
    step();
  endtask

  task automatic t_illegal_ret();
    logic [31:0] v;
    priv = 2'b00; mnret = 1'b1; #1;
    chk("R11 no return", {31'b0, redirect_valid}, 32'd0);
    chk("R11 illegal strobe", {31'b0, mnret_ill}, 32'd1);
    step();
    priv = 2'b00; pc = 32'h0000_0010; nmi_req = 4'b1000;
    step();
    rd(12'h352, v); chk("R5 cause line3", v, 32'h8000_0003);
    rd(12'h353, v); chk("R4 saved priv U", v, 32'h0);
    priv = 2'b00; pc = 32'h0000_0500; mnret = 1'b1; #1;
    chk("R11 nested target", redirect_pc, EV);
    chk("R11 nested cause", mcause, 32'd2);
    chk("R11 nested we", {31'b0, mcause_we}, 32'd1);
    step();
    chk("R11 en unchanged", {31'b0, irq_en}, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(12'h350, 32'h1111_2222);
    priv = 2'b11; pc = 32'h0000_0600; nmi_req = 4'b0100;
    csr_addr = 12'h350; csr_wdata = 32'h3333_4444; csr_we = 1'b1;
    step();
    rd(12'h350, v); chk("R12 write dropped", v, 32'h1111_2222);
    rd(12'h352, v); chk("R12 capture cause", v, 32'h8000_0002);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_csr_fields();
    t_entry_s();
    t_masked();
    t_nested();
    t_return(32'h8000_0042, 2'b01);
    t_exc_enabled();
    t_illegal_ret();
    t_return(32'h0000_0010, 2'b00);
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule